// File: doc/BRIEF.md
# Load-use hazard stall controller

This block sits in the decode stage of a five-stage in-order pipeline and decides, in the same cycle, whether the instruction now in decode must wait for a load ahead of it. When the instruction in execute reads memory and its destination register is one of the two source registers of the instruction in decode, the block holds the program counter and the fetch/decode pipeline register for one cycle. It also clears every control bit (execute, memory and writeback groups) that would enter the decode/execute register, so a no-op travels down the pipeline in place of the consumer.

The block has no state. The one-cycle length of the stall comes from the pipeline around it: the inserted no-op has its memory-read bit at zero, so the next cycle sees no load in execute. The consumer then proceeds and gets the load data through forwarding from the memory/writeback register. Register 0 is hard-wired to zero, so a load that targets it never causes a stall (selectable by parameter).

Top module: `load_use_guard`

## Requirements
- R1: When `idex_mem_read` is 1, `idex_rt` is non-zero and `idex_rt` equals `ifid_rs`, a stall is raised in the same cycle.
- R2: When `idex_mem_read` is 1, `idex_rt` is non-zero and `idex_rt` equals `ifid_rt`, a stall is raised in the same cycle. A match on both sources raises the same single stall.
- R3: When `idex_mem_read` is 0, no stall is raised, whatever the register numbers are.
- R4: With `ZERO_GUARD` = 1 (default), `idex_rt` = 0 never raises a stall, even when a source is also 0.
- R5: During a stall `pc_write` and `ifid_write` are both 0. Otherwise both are 1.
- R6: During a stall `ctrl_zero` is 1 and `idex_ex_ctrl`, `idex_mem_ctrl` and `idex_wb_ctrl` are all zero. Otherwise `ctrl_zero` is 0 and the three outputs equal `dec_ex_ctrl`, `dec_mem_ctrl` and `dec_wb_ctrl`.
- R7: In a pipeline where bit 0 of the memory control group is the memory-read bit fed back as `idex_mem_read`, each load-use pair costs exactly one stall. PC and fetch/decode contents are held for exactly that cycle. In the next cycle the decode/execute register holds all-zero control and no stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_mem_read | input | 1 | Memory-read bit of the instruction in execute |
| idex_rt | input | REG_W | Destination register of the instruction in execute |
| ifid_rs | input | REG_W | First source register of the instruction in decode |
| ifid_rt | input | REG_W | Second source register of the instruction in decode |
| dec_ex_ctrl | input | EX_W | Execute-group control bits from the decoder |
| dec_mem_ctrl | input | MEM_W | Memory-group control bits from the decoder |
| dec_wb_ctrl | input | WB_W | Writeback-group control bits from the decoder |
| pc_write | output | 1 | PC load enable, low during a stall |
| ifid_write | output | 1 | Fetch/decode register load enable, low during a stall |
| ctrl_zero | output | 1 | Bubble select, high during a stall |
| idex_ex_ctrl | output | EX_W | Execute-group bits toward the decode/execute register |
| idex_mem_ctrl | output | MEM_W | Memory-group bits toward the decode/execute register |
| idex_wb_ctrl | output | WB_W | Writeback-group bits toward the decode/execute register |

## Verification
Two comparator hits can occur in the same cycle: a load's destination can match both sources of the consumer. The zero-register guard can also coincide with a match, when a load to register 0 meets a consumer that reads register 0. Both cases are forced with directed instructions at the head of the stream and arise again in the random part, where register numbers come from only four values. A bench model of the pipeline registers judges each cycle. It checks that a double hit gives one stall with one held cycle and one zeroed decode/execute entry, and that the guarded case leaves the enables high and the control fields unchanged.

// File: rtl/lu_pkg.sv
package lu_pkg;

  localparam int unsigned NUM_SRC = 2;

  typedef enum logic {
    SEL_PASS = 1'b0,
    SEL_ZERO = 1'b1
  } ctrl_sel_e;

  function automatic logic any_set(input logic [NUM_SRC-1:0] v);
    return |v;
  endfunction

endpackage

// File: rtl/lu_match.sv
module lu_match #(
  parameter int unsigned REG_W      = 5,
  parameter bit          ZERO_GUARD = 1'b1
) (
  input  logic [REG_W-1:0] prod_reg,
  input  logic [REG_W-1:0] src_reg,
  output logic             hit
);

  function automatic logic same_reg(input logic [REG_W-1:0] a,
                                    input logic [REG_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  generate
    if (ZERO_GUARD) begin : g_guarded
      logic prod_live;
      assign prod_live = |prod_reg;
      assign hit       = prod_live & same_reg(prod_reg, src_reg);
    end else begin : g_plain
      assign hit = same_reg(prod_reg, src_reg);
    end
  endgenerate

endmodule

// File: rtl/lu_stall_decide.sv
module lu_stall_decide
  import lu_pkg::*;
(
  input  logic               mem_read,
  input  logic [NUM_SRC-1:0] src_hit,
  output logic               stall,
  output logic               pc_write,
  output logic               ifid_write,
  output ctrl_sel_e          sel
);

  always_comb begin
    stall      = mem_read & any_set(src_hit);
    pc_write   = ~stall;
    ifid_write = ~stall;
    sel        = stall ? SEL_ZERO : SEL_PASS;
  end

endmodule

// File: rtl/lu_ctrl_mux.sv
module lu_ctrl_mux
  import lu_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  ctrl_sel_e      sel,
  input  logic [W-1:0]   d,
  output logic [W-1:0]   q
);

  always_comb begin
    unique case (sel)
      SEL_ZERO: q = '0;
      default:  q = d;
    endcase
  end

endmodule

// File: rtl/load_use_guard.sv
module load_use_guard
  import lu_pkg::*;
#(
  parameter int unsigned REG_W      = 5,
  parameter int unsigned EX_W       = 4,
  parameter int unsigned MEM_W      = 3,
  parameter int unsigned WB_W       = 2,
  parameter bit          ZERO_GUARD = 1'b1
) (
  input  logic             idex_mem_read,
  input  logic [REG_W-1:0] idex_rt,
  input  logic [REG_W-1:0] ifid_rs,
  input  logic [REG_W-1:0] ifid_rt,
  input  logic [EX_W-1:0]  dec_ex_ctrl,
  input  logic [MEM_W-1:0] dec_mem_ctrl,
  input  logic [WB_W-1:0]  dec_wb_ctrl,
  output logic             pc_write,
  output logic             ifid_write,
  output logic             ctrl_zero,
  output logic [EX_W-1:0]  idex_ex_ctrl,
  output logic [MEM_W-1:0] idex_mem_ctrl,
  output logic [WB_W-1:0]  idex_wb_ctrl
);

  localparam int unsigned CTRL_W = EX_W + MEM_W + WB_W;

  logic [REG_W-1:0]   src_regs [NUM_SRC];
  logic [NUM_SRC-1:0] src_hit;
  logic               stall_evt;
  ctrl_sel_e          mux_sel;
  logic [CTRL_W-1:0]  ctrl_in;
  logic [CTRL_W-1:0]  ctrl_out;

  assign src_regs[0] = ifid_rs;
  assign src_regs[1] = ifid_rt;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      lu_match #(
        .REG_W      (REG_W),
        .ZERO_GUARD (ZERO_GUARD)
      ) u_match (
        .prod_reg (idex_rt),
        .src_reg  (src_regs[g]),
        .hit      (src_hit[g])
      );
    end
  endgenerate

  lu_stall_decide u_decide (
    .mem_read   (idex_mem_read),
    .src_hit    (src_hit),
    .stall      (stall_evt),
    .pc_write   (pc_write),
    .ifid_write (ifid_write),
    .sel        (mux_sel)
  );

  assign ctrl_in = {dec_ex_ctrl, dec_mem_ctrl, dec_wb_ctrl};

  lu_ctrl_mux #(.W(CTRL_W)) u_mux (
    .sel (mux_sel),
    .d   (ctrl_in),
    .q   (ctrl_out)
  );

  assign ctrl_zero = (mux_sel == SEL_ZERO);
  assign {idex_ex_ctrl, idex_mem_ctrl, idex_wb_ctrl} = ctrl_out;

endmodule

// File: rtl/lu_guard_chk.sv
module lu_guard_chk #(
  parameter int unsigned REG_W      = 5,
  parameter int unsigned EX_W       = 4,
  parameter int unsigned MEM_W      = 3,
  parameter int unsigned WB_W       = 2,
  parameter bit          ZERO_GUARD = 1'b1
) (
  input logic             idex_mem_read,
  input logic [REG_W-1:0] idex_rt,
  input logic [REG_W-1:0] ifid_rs,
  input logic [REG_W-1:0] ifid_rt,
  input logic [EX_W-1:0]  dec_ex_ctrl,
  input logic [MEM_W-1:0] dec_mem_ctrl,
  input logic [WB_W-1:0]  dec_wb_ctrl,
  input logic             pc_write,
  input logic             ifid_write,
  input logic             ctrl_zero,
  input logic [EX_W-1:0]  idex_ex_ctrl,
  input logic [MEM_W-1:0] idex_mem_ctrl,
  input logic [WB_W-1:0]  idex_wb_ctrl,
  input logic [1:0]       src_hit,
  input logic             stall_evt
);

  logic known;
  assign known = !$isunknown({idex_mem_read, idex_rt, ifid_rs, ifid_rt,
                              dec_ex_ctrl, dec_mem_ctrl, dec_wb_ctrl});

  always_comb begin
    if (known) begin
      // R1 R2: a stall needs a load and at least one comparator hit
      p_stall_cause_r1: assert (!ctrl_zero || (idex_mem_read && (src_hit != 2'b00)));
      // R3: no load, no stall
      p_no_load_r3: assert (idex_mem_read || !stall_evt);
      // R4: register 0 destination never stalls
      p_zero_dest_r4: assert (!ZERO_GUARD || (idex_rt != '0) || !ctrl_zero);
      // R5: enables track the decision together
      p_enables_r5: assert ((pc_write == ifid_write) && (pc_write == !stall_evt));
      // R6: bubble zeroes every field
      p_bubble_r6: assert (!ctrl_zero ||
                           ((idex_ex_ctrl == '0) && (idex_mem_ctrl == '0) && (idex_wb_ctrl == '0)));
      // R6: pass-through when no bubble
      p_pass_r6: assert (ctrl_zero ||
                         ((idex_ex_ctrl == dec_ex_ctrl) && (idex_mem_ctrl == dec_mem_ctrl) &&
                          (idex_wb_ctrl == dec_wb_ctrl)));
    end
  end

endmodule

bind load_use_guard lu_guard_chk #(
  .REG_W      (REG_W),
  .EX_W       (EX_W),
  .MEM_W      (MEM_W),
  .WB_W       (WB_W),
  .ZERO_GUARD (ZERO_GUARD)
) u_chk (
  .idex_mem_read (idex_mem_read),
  .idex_rt       (idex_rt),
  .ifid_rs       (ifid_rs),
  .ifid_rt       (ifid_rt),
  .dec_ex_ctrl   (dec_ex_ctrl),
  .dec_mem_ctrl  (dec_mem_ctrl),
  .dec_wb_ctrl   (dec_wb_ctrl),
  .pc_write      (pc_write),
  .ifid_write    (ifid_write),
  .ctrl_zero     (ctrl_zero),
  .idex_ex_ctrl  (idex_ex_ctrl),
  .idex_mem_ctrl (idex_mem_ctrl),
  .idex_wb_ctrl  (idex_wb_ctrl),
  .src_hit       (src_hit),
  .stall_evt     (stall_evt)
);

// File: tb/load_use_guard_bench.sv
`timescale 1ns/1ps
module load_use_guard_bench;

  typedef struct packed {
    logic       ld;
    logic [4:0] rs;
    logic [4:0] rt;
    logic [3:0] ex;
    logic [2:0] mem;
    logic [1:0] wb;
  } instr_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  instr_t      imem [0:255];
  logic [31:0] pc;
  instr_t      ifid;
  logic [4:0]  idex_rt;
  logic [3:0]  idex_ex;
  logic [2:0]  idex_mem;
  logic [1:0]  idex_wb;

  logic       pc_write, ifid_write, ctrl_zero;
  logic [3:0] o_ex;
  logic [2:0] o_mem;
  logic [1:0] o_wb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  load_use_guard u_load_use_guard (
    .idex_mem_read (idex_mem[0]),
    .idex_rt       (idex_rt),
    .ifid_rs       (ifid.rs),
    .ifid_rt       (ifid.rt),
    .dec_ex_ctrl   (ifid.ex),
    .dec_mem_ctrl  (ifid.mem),
    .dec_wb_ctrl   (ifid.wb),
    .pc_write      (pc_write),
    .ifid_write    (ifid_write),
    .ctrl_zero     (ctrl_zero),
    .idex_ex_ctrl  (o_ex),
    .idex_mem_ctrl (o_mem),
    .idex_wb_ctrl  (o_wb)
  );

  // shadow pipeline registers around the block
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; ifid <= '0; idex_rt <= '0;
      idex_ex <= '0; idex_mem <= '0; idex_wb <= '0;
    end else begin
      if (pc_write)   pc   <= pc + 32'd4;
      if (ifid_write) ifid <= imem[pc[9:2]];
      idex_rt  <= ifid.rt;
      idex_ex  <= o_ex;
      idex_mem <= o_mem;
      idex_wb  <= o_wb;
    end
  end

  function automatic bit want_stall(logic mr, logic [4:0] dst, logic [4:0] a, logic [4:0] b);
    if (mr !== 1'b1) return 0;
    if (dst == 5'd0) return 0;
    return (dst == a) || (dst == b);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic instr_t mk(bit ld, int rs, int rt);
    instr_t i;
    i.ld = ld; i.rs = 5'(rs); i.rt = 5'(rt);
    i.ex = 4'($urandom); i.wb = 2'($urandom);
    i.mem = {2'($urandom), ld};
    return i;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) imem[i] = mk(($urandom % 5) < 2, $urandom % 4, $urandom % 4);
    imem[0]  = mk(1, 1, 2);   // load to r2
    imem[1]  = mk(0, 2, 1);   // uses r2 as rs: R1
    imem[2]  = '0;
    imem[3]  = mk(1, 0, 3);   // load to r3
    imem[4]  = mk(0, 1, 3);   // uses r3 as rt: R2
    imem[5]  = mk(1, 2, 1);   // load to r1
    imem[6]  = mk(0, 1, 1);   // both sources: R2 double hit
    imem[7]  = mk(1, 2, 0);   // load to r0
    imem[8]  = mk(0, 0, 0);   // reads r0: R4
    imem[9]  = mk(0, 1, 2);   // non-load writing r2
    imem[10] = mk(0, 2, 2);   // R3
  end

  bit          prev_stall;
  logic [31:0] prev_pc;
  instr_t      prev_ifid;

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 reset pc_write", 32'(pc_write), 32'd1);
    chk("R5 reset ifid_write", 32'(ifid_write), 32'd1);
    chk("R6 reset ctrl_zero", 32'(ctrl_zero), 32'd0);
    rst_n = 1'b1;
    prev_stall = 0;
    prev_pc = pc;
    prev_ifid = ifid;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      begin
        bit s;
        s = want_stall(idex_mem[0], idex_rt, ifid.rs, ifid.rt);
        chk("R1 R2 R3 R4 ctrl_zero", 32'(ctrl_zero), 32'(s));
        chk("R5 pc_write", 32'(pc_write), 32'(!s));
        chk("R5 ifid_write", 32'(ifid_write), 32'(!s));
        chk("R6 mux out", {23'd0, o_ex, o_mem, o_wb},
            s ? 32'd0 : {23'd0, ifid.ex, ifid.mem, ifid.wb});
        if (c > 0) begin
          if (prev_stall) begin
            chk("R7 no second stall", 32'(ctrl_zero), 32'd0);
            chk("R7 pc held", pc, prev_pc);
            chk("R7 ifid held", 32'(ifid), 32'(prev_ifid));
            chk("R7 idex bubble", {23'd0, idex_ex, idex_mem, idex_wb}, 32'd0);
          end else begin
            chk("R7 pc advances", pc, prev_pc + 32'd4);
            chk("R7 idex takes decode", {23'd0, idex_ex, idex_mem, idex_wb},
                {23'd0, prev_ifid.ex, prev_ifid.mem, prev_ifid.wb});
          end
        end
        prev_stall = s;
        prev_pc = pc;
        prev_ifid = ifid;
      end
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule